// File: doc/BRIEF.md
# Sequential stream buffer

This block is a small ring of prefetched cache blocks placed between a direct-mapped cache and the next memory level. When the cache misses, it presents the missing block address here before memory is involved. Only the oldest entry, the head, is compared with the miss. If the head holds that block, the block goes to the cache. The head slot is then reused for the next block in the sequential run, and a prefetch for that block goes out to memory. Prefetched blocks stay in the ring until the cache asks for them, so they never displace lines the cache already holds.

When the miss does not match the head, the whole ring is dropped. The missing block is fetched on demand, and the ring is loaded again with the DEPTH blocks that follow the missing one. A head whose request is still in flight counts as a hit that has to wait: the lookup stalls until the data comes back and sends no second request. Every request carries an identifier with an allocation epoch. A response from before the last flush therefore finds no slot to land in.

Addresses are block addresses, one unit per cache block. The cache holds `miss_valid` and `miss_addr` steady until it sees `fill_valid`. It can present its next miss in the cycle that follows.

Top module: `sb_stream_buf`

## Requirements
- R1: While reset is held, and until the first miss, `fill_valid` and `mem_req_valid` stay low. The ring starts empty, so the first miss is handled as a mismatch.
- R2: A miss that does not match the head flushes the ring. The block then issues a demand request for the miss address first. Prefetch requests for miss+1, miss+2, ... miss+DEPTH follow in ascending order, each issued once.
- R3: A demand response from the current epoch produces a fill with `fill_hit`=0, `fill_data` equal to the response data and `fill_addr` equal to the held miss address. `fill_valid` is high for exactly one cycle.
- R4: A miss that matches a head whose data is present raises `fill_valid` with `fill_hit`=1 in the cycle after the miss is first sampled. The fill carries the prefetched data, and no demand request is made.
- R5: Each consumed head issues exactly one new prefetch, for the address one past the last block allocated. Addresses wrap modulo 2^ADDR_W.
- R6: A miss that matches a head whose data has not yet returned waits for that data. It issues no other request and fills as soon as the data arrives.
- R7: Only the head is compared. A miss on a block that sits in a later slot is handled as a mismatch, as in R2.
- R8: A prefetch response whose epoch differs from the current epoch changes no slot. A later hit on a refilled slot waits for, and returns, the newer data.
- R9: `mem_req_id` is {demand bit (MSB), slot (IDX_W bits), epoch (SEQ_W bits, LSBs)}. The epoch starts at 0 and increments on every flush. After a flush, the block miss+1+j sits in slot j. A consumed slot is refilled in place, and slots are consumed in ring order. A demand request holds its address steady while `mem_req_ready` is low. Responses echo the identifier and may return in any order.
- R10: `fill_valid` is raised only in response to a miss that was presented in the previous cycle. Prefetched data is never pushed into the cache unasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Cache miss lookup, held until fill |
| miss_addr | input | ADDR_W | Missing block address |
| fill_valid | output | 1 | One-cycle block transfer to the cache |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | DATA_W | Block data |
| fill_hit | output | 1 | 1 = served from the ring, 0 = demand fetched |
| mem_req_valid | output | 1 | Request to next level |
| mem_req_ready | input | 1 | Next level accepts request |
| mem_req_addr | output | ADDR_W | Requested block address |
| mem_req_id | output | 1+IDX_W+SEQ_W | Request identifier (R9) |
| mem_rsp_valid | input | 1 | Response from next level |
| mem_rsp_id | input | 1+IDX_W+SEQ_W | Echoed identifier |
| mem_rsp_data | input | DATA_W | Returned block data |

## Verification
Some properties are checked on every cycle. A fill is a single-cycle pulse caused by a miss presented in the previous cycle, and its address is the held miss address. A slot is consumed only when its data is present. A flush leaves no slot marked ready. A stalled demand request keeps its address. Other behaviour shows only in the bench's scenarios. These include the order and identifiers of the request stream after a flush or after a pop, the one-cycle hit latency, and waiting on a pending head. A non-head match has to be treated as a miss. Responses from a dropped epoch must be rejected: the bench releases them before the newer data, so a slot that accepted them would fill early with wrong contents.

// File: rtl/sb_pkg.sv
// Shared types for the sequential stream buffer.
package sb_pkg;

    // Lookup controller states.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,   // waiting for a miss
        ST_WAIT_HEAD = 2'd1,   // head matched, data still in flight
        ST_WAIT_DEM  = 2'd2,   // ring flushed, demand fetch in flight
        ST_RESP      = 2'd3    // fill presented to the cache
    } sb_state_e;

endpackage

// File: rtl/sb_store.sv
// Ring storage for the stream buffer: per-slot tag, data, ready and issued
// flags, the head pointer, the next sequential address and the epoch.
// Assumes DEPTH is a power of two, at least 2. A pop is only requested for a
// ready head, and an epoch value does not wrap while a response is in flight.
module sb_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [ADDR_W-1:0]              flush_addr,
    input  logic                           pop,
    input  logic                           iss_fire,
    input  logic [IDX_W-1:0]               iss_slot,
    input  logic                           rsp_valid,
    input  logic                           rsp_demand,
    input  logic [IDX_W-1:0]               rsp_slot,
    input  logic [SEQ_W-1:0]               rsp_epoch,
    input  logic [DATA_W-1:0]              rsp_data,
    output logic [DEPTH-1:0]               alloc_vec,
    output logic [DEPTH-1:0]               issued_vec,
    output logic [DEPTH-1:0][ADDR_W-1:0]   tags,
    output logic [IDX_W-1:0]               head,
    output logic [SEQ_W-1:0]               epoch,
    output logic                           head_alloc,
    output logic                           head_ready,
    output logic [ADDR_W-1:0]              head_tag,
    output logic [DATA_W-1:0]              head_data
);

    logic [DEPTH-1:0]             alloc_q, issued_q, ready_q;
    logic [DEPTH-1:0][ADDR_W-1:0] tag_q;
    logic [DATA_W-1:0]            data_q [DEPTH];
    logic [IDX_W-1:0]             head_q;
    logic [ADDR_W-1:0]            nxt_q;
    logic [SEQ_W-1:0]             epoch_q;
    logic                         rsp_ok;

    // Accept a prefetch response only for a live slot of the current epoch.
    assign rsp_ok = rsp_valid && !rsp_demand && (rsp_epoch == epoch_q)
                    && alloc_q[rsp_slot];

    // Control state: flush reloads the ring, pop recycles the head slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q  <= '0;
            issued_q <= '0;
            ready_q  <= '0;
            tag_q    <= '0;
            head_q   <= '0;
            nxt_q    <= '0;
            epoch_q  <= '0;
        end else if (flush) begin
            epoch_q <= epoch_q + 1'b1;
            head_q  <= '0;
            nxt_q   <= flush_addr + ADDR_W'(DEPTH + 1);
            for (int j = 0; j < DEPTH; j++) begin
                alloc_q[j]  <= 1'b1;
                issued_q[j] <= 1'b0;
                ready_q[j]  <= 1'b0;
                tag_q[j]    <= flush_addr + ADDR_W'(j + 1);
            end
        end else begin
            if (iss_fire)
                issued_q[iss_slot] <= 1'b1;
            if (rsp_ok)
                ready_q[rsp_slot] <= 1'b1;
            if (pop) begin
                tag_q[head_q]    <= nxt_q;
                issued_q[head_q] <= 1'b0;
                ready_q[head_q]  <= 1'b0;
                nxt_q            <= nxt_q + 1'b1;
                head_q           <= head_q + 1'b1;
            end
        end
    end

    // Data capture for accepted prefetch responses.
    always_ff @(posedge clk) begin
        if (rsp_ok)
            data_q[rsp_slot] <= rsp_data;
    end

    assign alloc_vec  = alloc_q;
    assign issued_vec = issued_q;
    assign tags       = tag_q;
    assign head       = head_q;
    assign epoch      = epoch_q;
    assign head_alloc = alloc_q[head_q];
    assign head_ready = ready_q[head_q];
    assign head_tag   = tag_q[head_q];
    assign head_data  = data_q[head_q];

    // R6
    pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (alloc_q[head_q] && ready_q[head_q]));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ready_q == '0));

endmodule

// File: rtl/sb_issue.sv
// Request issue to the next memory level. A pending demand fetch always goes
// first. Otherwise the oldest allocated, unissued slot, counted from the head,
// is requested. Nothing is issued in a flush cycle.
// Assumes at most one demand fetch is outstanding.
module sb_issue #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ID_W  = 1 + IDX_W + SEQ_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [ADDR_W-1:0]            dem_addr,
    input  logic [DEPTH-1:0]             alloc_vec,
    input  logic [DEPTH-1:0]             issued_vec,
    input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
    input  logic [IDX_W-1:0]             head,
    input  logic [SEQ_W-1:0]             epoch,
    input  logic                         req_ready,
    output logic                         req_valid,
    output logic [ADDR_W-1:0]            req_addr,
    output logic [ID_W-1:0]              req_id,
    output logic                         pf_fire,
    output logic [IDX_W-1:0]             pf_slot
);

    logic              dem_pend_q;
    logic [ADDR_W-1:0] dem_addr_q;
    logic              found;
    logic [IDX_W-1:0]  pick;

    // Demand tracker: armed by a flush, cleared when the request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dem_pend_q <= 1'b0;
            dem_addr_q <= '0;
        end else if (flush) begin
            dem_pend_q <= 1'b1;
            dem_addr_q <= dem_addr;
        end else if (dem_pend_q && req_ready) begin
            dem_pend_q <= 1'b0;
        end
    end

    // Oldest-first scan of the ring, starting at the head.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [IDX_W-1:0] idx;
            idx = head + IDX_W'(i);
            if (!found && alloc_vec[idx] && !issued_vec[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

    // Request mux: demand first, then the selected prefetch slot.
    always_comb begin
        req_valid = (dem_pend_q || found) && !flush;
        req_addr  = dem_pend_q ? dem_addr_q : tags[pick];
        req_id    = {dem_pend_q, (dem_pend_q ? {IDX_W{1'b0}} : pick), epoch};
        pf_fire   = req_valid && req_ready && !dem_pend_q;
        pf_slot   = pick;
    end

    // R9
    dem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_id[ID_W-1] && !req_ready) |=>
        (req_valid && req_id[ID_W-1] && $stable(req_addr)));

endmodule

// File: rtl/sb_ctrl.sv
// Lookup controller: compares the miss against the head and picks hit,
// pending hit or flush. It also registers the block handed to the cache.
// Assumes the cache holds miss_valid and miss_addr until fill_valid.
module sb_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              head_alloc,
    input  logic              head_ready,
    input  logic [ADDR_W-1:0] head_tag,
    input  logic [DATA_W-1:0] head_data,
    input  logic              rsp_valid,
    input  logic              rsp_demand,
    input  logic [SEQ_W-1:0]  rsp_epoch,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [SEQ_W-1:0]  epoch,
    output logic              flush,
    output logic              pop,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_hit
);
    import sb_pkg::*;

    sb_state_e         st_q;
    logic              head_match, dem_done;
    logic [ADDR_W-1:0] f_addr_q;
    logic [DATA_W-1:0] f_data_q;
    logic              f_hit_q;

    // Head comparison and the resulting one-cycle commands.
    always_comb begin
        head_match = head_alloc && (head_tag == miss_addr);
        flush      = (st_q == ST_IDLE) && miss_valid && !head_match;
        pop        = (((st_q == ST_IDLE) && miss_valid && head_match)
                      || (st_q == ST_WAIT_HEAD)) && head_ready;
        dem_done   = (st_q == ST_WAIT_DEM) && rsp_valid && rsp_demand
                      && (rsp_epoch == epoch);
    end

    // Lookup sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        if (!head_match)     st_q <= ST_WAIT_DEM;
                        else if (head_ready) st_q <= ST_RESP;
                        else                 st_q <= ST_WAIT_HEAD;
                    end
                end
                ST_WAIT_HEAD: if (head_ready) st_q <= ST_RESP;
                ST_WAIT_DEM:  if (dem_done)   st_q <= ST_RESP;
                default:                      st_q <= ST_IDLE;
            endcase
        end
    end

    // Fill register: loaded from the head on a pop, or from a demand response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_addr_q <= '0;
            f_data_q <= '0;
            f_hit_q  <= 1'b0;
        end else if (pop) begin
            f_addr_q <= miss_addr;
            f_data_q <= head_data;
            f_hit_q  <= 1'b1;
        end else if (dem_done) begin
            f_addr_q <= miss_addr;
            f_data_q <= rsp_data;
            f_hit_q  <= 1'b0;
        end
    end

    assign fill_valid = (st_q == ST_RESP);
    assign fill_addr  = f_addr_q;
    assign fill_data  = f_data_q;
    assign fill_hit   = f_hit_q;

    // R3
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R3
    fill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (fill_addr == miss_addr));

    // R10
    fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(miss_valid));

endmodule

// File: rtl/sb_stream_buf.sv
// Sequential stream buffer top: ties the ring storage, the request issue unit
// and the lookup controller together, and splits the response identifier.
// Assumes block-granular addresses and DEPTH a power of two, at least 2.
module sb_stream_buf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ID_W  = 1 + IDX_W + SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_hit,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ID_W-1:0]   mem_req_id,
    input  logic              mem_rsp_valid,
    input  logic [ID_W-1:0]   mem_rsp_id,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic                         flush, pop, pf_fire;
    logic [IDX_W-1:0]             pf_slot, head;
    logic [DEPTH-1:0]             alloc_vec, issued_vec;
    logic [DEPTH-1:0][ADDR_W-1:0] tags;
    logic [SEQ_W-1:0]             epoch;
    logic                         head_alloc, head_ready;
    logic [ADDR_W-1:0]            head_tag;
    logic [DATA_W-1:0]            head_data;
    logic                         rsp_demand;
    logic [IDX_W-1:0]             rsp_slot;
    logic [SEQ_W-1:0]             rsp_epoch;

    // Identifier fields: demand flag, slot, epoch.
    assign rsp_demand = mem_rsp_id[ID_W-1];
    assign rsp_slot   = mem_rsp_id[SEQ_W +: IDX_W];
    assign rsp_epoch  = mem_rsp_id[SEQ_W-1:0];

    sb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .flush(flush), .flush_addr(miss_addr), .pop(pop),
        .iss_fire(pf_fire), .iss_slot(pf_slot),
        .rsp_valid(mem_rsp_valid), .rsp_demand(rsp_demand), .rsp_slot(rsp_slot),
        .rsp_epoch(rsp_epoch), .rsp_data(mem_rsp_data),
        .alloc_vec(alloc_vec), .issued_vec(issued_vec), .tags(tags),
        .head(head), .epoch(epoch),
        .head_alloc(head_alloc), .head_ready(head_ready),
        .head_tag(head_tag), .head_data(head_data)
    );

    sb_issue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SEQ_W(SEQ_W)) issue_i (
        .clk(clk), .rst_n(rst_n),
        .flush(flush), .dem_addr(miss_addr),
        .alloc_vec(alloc_vec), .issued_vec(issued_vec), .tags(tags),
        .head(head), .epoch(epoch), .req_ready(mem_req_ready),
        .req_valid(mem_req_valid), .req_addr(mem_req_addr), .req_id(mem_req_id),
        .pf_fire(pf_fire), .pf_slot(pf_slot)
    );

    sb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .head_alloc(head_alloc), .head_ready(head_ready),
        .head_tag(head_tag), .head_data(head_data),
        .rsp_valid(mem_rsp_valid), .rsp_demand(rsp_demand),
        .rsp_epoch(rsp_epoch), .rsp_data(mem_rsp_data), .epoch(epoch),
        .flush(flush), .pop(pop),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_hit(fill_hit)
    );

endmodule

// File: tb/sb_stream_buf_tb_top.sv
// Scoreboard bench. Drivers push the expected requests and fills into queues;
// the memory model and the fill monitor pop and compare them. Inputs change
// on the falling edge; the memory model acts 1 ns after the falling edge.
module sb_stream_buf_tb_top;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int DP  = 4;
    localparam int SW  = 3;
    localparam int IW  = 2;
    localparam int IDW = 1 + IW + SW;
    localparam int LAT = 3;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          dem;
        logic [IW-1:0] slot;
        logic [SW-1:0] ep;
    } req_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          hit;
    } fill_t;

    typedef struct packed {
        logic [IDW-1:0] id;
        logic [AW-1:0]  addr;
        logic [31:0]    t;
    } pend_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           miss_valid = 1'b0;
    logic [AW-1:0]  miss_addr = '0;
    logic           fill_valid, fill_hit;
    logic [AW-1:0]  fill_addr;
    logic [DW-1:0]  fill_data;
    logic           mem_req_valid;
    logic           mem_req_ready = 1'b0;
    logic [AW-1:0]  mem_req_addr;
    logic [IDW-1:0] mem_req_id;
    logic           mem_rsp_valid = 1'b0;
    logic [IDW-1:0] mem_rsp_id = '0;
    logic [DW-1:0]  mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;

    req_t  exp_req_q [$];
    fill_t exp_fill_q [$];
    pend_t dq [$];
    pend_t pq [$];
    bit    hold = 1'b0;
    int    credit = 0;
    int    cyc = 0;

    logic [SW-1:0] b_ep = '0;
    logic [IW-1:0] b_head = '0;
    logic [AW-1:0] b_next = '0;

    always #4 clk = ~clk;

    sb_stream_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP), .SEQ_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_hit(fill_hit),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_id(mem_req_id),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Expected traffic after a flush (R2, R9).
    task automatic exp_flush(input logic [AW-1:0] a);
        b_ep   = b_ep + 1'b1;
        b_head = '0;
        exp_req_q.push_back('{addr: a, dem: 1'b1, slot: '0, ep: b_ep});
        for (int j = 0; j < DP; j++)
            exp_req_q.push_back('{addr: a + AW'(j + 1), dem: 1'b0,
                                  slot: IW'(j), ep: b_ep});
        b_next = a + AW'(DP + 1);
    endtask

    // Expected refill after a consumed head (R5).
    task automatic exp_pop();
        exp_req_q.push_back('{addr: b_next, dem: 1'b0, slot: b_head, ep: b_ep});
        b_next = b_next + 1'b1;
        b_head = b_head + 1'b1;
    endtask

    // Present one miss and wait for its fill; returns the latency in cycles.
    task automatic do_miss(input logic [AW-1:0] a, input logic hit, output int lat);
        exp_fill_q.push_back('{addr: a, data: blk(a), hit: hit});
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!fill_valid);
        miss_valid = 1'b0;
    endtask

    // Memory model and request monitor (R2 R5 R9).
    always begin
        @(negedge clk);
        #1;
        cyc++;
        mem_req_ready = (cyc % 4) != 3;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            req_t act;
            act = '{addr: mem_req_addr, dem: mem_req_id[IDW-1],
                    slot: mem_req_id[SW +: IW], ep: mem_req_id[SW-1:0]};
            if (exp_req_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected request", 64'(act), 64'(0));
            end else begin
                req_t e;
                e = exp_req_q.pop_front();
                chk(act == e, "R2 R5 R9", "request", 64'(act), 64'(e));
            end
            if (mem_req_id[IDW-1])
                dq.push_back('{id: mem_req_id, addr: mem_req_addr, t: 32'(cyc)});
            else
                pq.push_back('{id: mem_req_id, addr: mem_req_addr, t: 32'(cyc)});
        end
        mem_rsp_valid = 1'b0;
        if (dq.size() > 0 && cyc >= int'(dq[0].t) + LAT) begin
            pend_t p;
            p = dq.pop_front();
            mem_rsp_valid = 1'b1;
            mem_rsp_id    = p.id;
            mem_rsp_data  = blk(p.addr);
        end else if (pq.size() > 0 && cyc >= int'(pq[0].t) + LAT
                     && (!hold || credit > 0)) begin
            pend_t p;
            p = pq.pop_front();
            if (hold) credit--;
            mem_rsp_valid = 1'b1;
            mem_rsp_id    = p.id;
            mem_rsp_data  = blk(p.addr);
        end
    end

    // Fill monitor (R3 R4 R10).
    always @(negedge clk) begin
        if (rst_n && fill_valid) begin
            fill_t act;
            act = '{addr: fill_addr, data: fill_data, hit: fill_hit};
            if (exp_fill_q.size() == 0) begin
                chk(1'b0, "R10", "unrequested fill", 64'(act), 64'(0));
            end else begin
                fill_t e;
                e = exp_fill_q.pop_front();
                chk(act == e, "R3 R4", "fill", 64'(act), 64'(e));
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        // R1: quiet during and after reset.
        repeat (4) @(negedge clk);
        chk(!fill_valid && !mem_req_valid, "R1", "outputs in reset",
            64'({fill_valid, mem_req_valid}), 64'(0));
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!fill_valid && !mem_req_valid, "R1", "outputs idle after reset",
            64'({fill_valid, mem_req_valid}), 64'(0));

        // R1 R2: first miss goes to memory, ring loads the next blocks.
        exp_flush(16'h0100);
        do_miss(16'h0100, 1'b0, lat);
        repeat (30) @(negedge clk);

        // R4 R5: ready head hits, one refill each.
        exp_pop(); do_miss(16'h0101, 1'b1, lat);
        chk(lat == 1, "R4", "hit latency", 64'(lat), 64'(1));
        exp_pop(); do_miss(16'h0102, 1'b1, lat);
        chk(lat == 1, "R4", "hit latency", 64'(lat), 64'(1));
        repeat (20) @(negedge clk);

        // R6: hold prefetch responses, drain ready entries, then hit a pending head.
        hold = 1'b1;
        exp_pop(); do_miss(16'h0103, 1'b1, lat);
        exp_pop(); do_miss(16'h0104, 1'b1, lat);
        exp_pop(); do_miss(16'h0105, 1'b1, lat);
        exp_pop(); do_miss(16'h0106, 1'b1, lat);
        chk(lat == 1, "R4", "hit latency", 64'(lat), 64'(1));
        exp_pop();
        fork
            do_miss(16'h0107, 1'b1, lat);
            begin
                repeat (20) @(negedge clk);
                credit = 1;
            end
        join
        chk(lat > 20, "R6", "pending hit waited", 64'(lat), 64'(21));
        repeat (10) @(negedge clk);

        // R7: block present in a later slot is still a miss.
        exp_flush(16'h010A);
        do_miss(16'h010A, 1'b0, lat);
        chk(lat > 1, "R7", "non-head match not served from ring", 64'(lat), 64'(2));
        repeat (10) @(negedge clk);

        // R8: release only the dropped-epoch responses, then hit the head.
        credit = 4;
        repeat (20) @(negedge clk);
        exp_pop();
        fork
            do_miss(16'h010B, 1'b1, lat);
            begin
                repeat (15) @(negedge clk);
                hold = 1'b0;
            end
        join
        chk(lat > 15, "R8", "stale response ignored", 64'(lat), 64'(16));
        repeat (20) @(negedge clk);
        exp_pop(); do_miss(16'h010C, 1'b1, lat);
        chk(lat == 1, "R4", "hit latency", 64'(lat), 64'(1));
        exp_pop(); do_miss(16'h010D, 1'b1, lat);
        exp_pop(); do_miss(16'h010E, 1'b1, lat);

        // R2: unrelated miss, then a run that wraps the address space (R5).
        exp_flush(16'h0300);
        do_miss(16'h0300, 1'b0, lat);
        repeat (30) @(negedge clk);
        exp_pop(); do_miss(16'h0301, 1'b1, lat);
        exp_flush(16'hFFFE);
        do_miss(16'hFFFE, 1'b0, lat);
        repeat (30) @(negedge clk);
        exp_pop(); do_miss(16'hFFFF, 1'b1, lat);
        exp_pop(); do_miss(16'h0000, 1'b1, lat);
        chk(lat == 1, "R5", "hit after wrap", 64'(lat), 64'(1));
        repeat (30) @(negedge clk);

        chk(exp_req_q.size() == 0, "R2", "requests outstanding",
            64'(exp_req_q.size()), 64'(0));
        chk(exp_fill_q.size() == 0, "R3", "fills outstanding",
            64'(exp_fill_q.size()), 64'(0));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule